// File: doc/BRIEF.md
# Descriptor Ring Memory Copy Engine

This engine moves 32-bit words between a host-side memory port and a local block RAM. Software describes each move in a 32-byte descriptor. The descriptors sit in a ring in host memory. Software starts work by writing a new producer index. The engine then walks the ring from its consumer index up to that producer index. For each descriptor it does three things: it fetches the descriptor, it copies the requested words, and it writes the advanced consumer index into a status word in host memory.

Software learns of progress by polling that status word. It can also enable a one-cycle interrupt pulse. The pulse is raised once the ring has drained.

Descriptor word layout, in 32-bit words at `ring_base_i + index*32`:
- Word 0 holds the source byte address. Only its low 32 bits are used.
- Word 2 holds the control word.
- Word 4 holds the destination byte address.
- Words 1, 3, 5, 6 and 7 are reserved.

Top module: `ring_copy_engine`

## Requirements
- R1: While reset is asserted and after its release, `irq_o`, `hm_req_o` and `lm_req_o` are low, and the consumer index is 0.
- R2: The engine leaves the idle state only after a write on `pidx_we_i` that makes the producer index differ from the consumer index. A producer write equal to the consumer index causes no memory request.
- R3: A descriptor is fetched as eight sequential word reads from `ring_base_i + cidx*32`. Word 0 is the source, word 2 the control word and word 4 the destination. Reserved words have no effect.
- R4: Control bit 31 selects the direction. A value of 0 reads host memory and writes the local RAM (local word address = byte address / 4). A value of 1 reads the local RAM and writes host memory.
- R5: Control bits [12:0] give a byte length. The word count is length/4, with leftover bytes dropped. Lengths above 4096 are treated as 4096 (1024 words).
- R6: A descriptor with a word count of zero makes no local RAM access and no copy access. It still completes and advances the consumer index.
- R7: Descriptors are processed strictly in ring order. Indices wrap modulo `RING_DEPTH`, and the ring is empty when both indices are equal.
- R8: After each descriptor, the engine writes the new consumer index, zero-extended, to `status_addr_i`.
- R9: When `irq_en_i` is 1, `irq_o` pulses for exactly one cycle after a status write that leaves the ring empty. When `irq_en_i` is 0, it never pulses.
- R10: A copy of N words performs its N destination writes on N consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ring_base_i | input | AW | Byte address of ring slot 0 in host memory |
| status_addr_i | input | AW | Byte address of the completion status word |
| irq_en_i | input | 1 | Enables the drain interrupt |
| pidx_we_i | input | 1 | Producer index write strobe |
| pidx_wdata_i | input | IW | New producer index |
| hm_req_o | output | 1 | Host memory request |
| hm_we_o | output | 1 | Host memory write (1) or read (0) |
| hm_addr_o | output | AW | Host memory byte address |
| hm_wdata_o | output | 32 | Host memory write data |
| hm_rdata_i | input | 32 | Host read data, valid one cycle after a read request |
| lm_req_o | output | 1 | Local RAM request |
| lm_we_o | output | 1 | Local RAM write (1) or read (0) |
| lm_addr_o | output | LAW | Local RAM word address |
| lm_wdata_o | output | 32 | Local RAM write data |
| lm_rdata_i | input | 32 | Local RAM read data, valid one cycle after a read request |
| irq_o | output | 1 | Single-cycle completion interrupt |

## Verification
The bench builds the engine with `RING_DEPTH` = 4, `AW` = 32 and `LAW` = 10.

A four-slot ring lets the consumer index wrap back to 0 within six descriptors. That puts a batch spanning the wrap point within reach.

Ten local address bits give exactly 4 KB of local RAM. The clamped maximum descriptor therefore fills the whole RAM, and a missing clamp shows up as a write past the end of the host destination.

// File: rtl/rce_pkg.sv
package rce_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned DESC_WRDS = 8;
  localparam int unsigned MAX_BYTES = 4096;
  localparam int unsigned MAX_WORDS = MAX_BYTES / 4;
  localparam int unsigned CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int unsigned DIR_BIT   = 31;
  localparam int unsigned LEN_W     = 13;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_COPY, ST_STATUS} eng_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] dst;
  } desc_t;

  // byte length -> word count, clamped at the per-descriptor maximum
  function automatic logic [CNT_W-1:0] len_to_words(input logic [WORD_W-1:0] ctrl);
    logic [LEN_W-1:0] b;
    b = ctrl[LEN_W-1:0];
    if (b > LEN_W'(MAX_BYTES)) return CNT_W'(MAX_WORDS);
    return CNT_W'(b >> 2);
  endfunction
endpackage

// File: rtl/rce_ring_idx.sv
module rce_ring_idx #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned IW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [IW-1:0] set_val_i,
  input  logic          adv_i,
  output logic [IW-1:0] pidx_o,
  output logic [IW-1:0] cidx_o,
  output logic [IW-1:0] cidx_nxt_o,
  output logic          empty_o
);
  logic [IW-1:0] pidx_q, cidx_q;

  assign cidx_nxt_o = cidx_q + IW'(1);
  assign pidx_o     = pidx_q;
  assign cidx_o     = cidx_q;
  assign empty_o    = (pidx_q == cidx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pidx_q <= '0;
      cidx_q <= '0;
    end else begin
      if (set_i) pidx_q <= set_val_i;
      if (adv_i) cidx_q <= cidx_nxt_o;
    end
  end

  assert_cidx_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cidx_q != $past(cidx_q)) |-> (cidx_q == IW'($past(cidx_q) + IW'(1))));

  assert_no_pop_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> !empty_o);
endmodule

// File: rtl/rce_copier.sv
module rce_copier
  import rce_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned LAW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              c2h_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [CNT_W-1:0]  nwords_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hm_req_o,
  output logic              hm_we_o,
  output logic [AW-1:0]     hm_addr_o,
  output logic [WORD_W-1:0] hm_wdata_o,
  input  logic [WORD_W-1:0] hm_rdata_i,
  output logic              lm_req_o,
  output logic              lm_we_o,
  output logic [LAW-1:0]    lm_addr_o,
  output logic [WORD_W-1:0] lm_wdata_o,
  input  logic [WORD_W-1:0] lm_rdata_i
);
  logic             busy_q, done_q, pend_q, c2h_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] n_q, rd_idx_q, wr_idx_q;
  logic             rd_go, last_wr;

  assign rd_go   = busy_q && (rd_idx_q != n_q);
  assign last_wr = pend_q && (CNT_W'(wr_idx_q + CNT_W'(1)) == n_q);
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  always_comb begin
    hm_req_o   = 1'b0;
    hm_we_o    = 1'b0;
    hm_addr_o  = '0;
    hm_wdata_o = '0;
    lm_req_o   = 1'b0;
    lm_we_o    = 1'b0;
    lm_addr_o  = '0;
    lm_wdata_o = '0;
    if (rd_go) begin
      if (c2h_q) begin
        lm_req_o  = 1'b1;
        lm_addr_o = src_q[LAW+1:2] + LAW'(rd_idx_q);
      end else begin
        hm_req_o  = 1'b1;
        hm_addr_o = src_q + (AW'(rd_idx_q) << 2);
      end
    end
    if (pend_q) begin
      if (c2h_q) begin
        hm_req_o   = 1'b1;
        hm_we_o    = 1'b1;
        hm_addr_o  = dst_q + (AW'(wr_idx_q) << 2);
        hm_wdata_o = lm_rdata_i;
      end else begin
        lm_req_o   = 1'b1;
        lm_we_o    = 1'b1;
        lm_addr_o  = dst_q[LAW+1:2] + LAW'(wr_idx_q);
        lm_wdata_o = hm_rdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      pend_q   <= 1'b0;
      c2h_q    <= 1'b0;
      src_q    <= '0;
      dst_q    <= '0;
      n_q      <= '0;
      rd_idx_q <= '0;
      wr_idx_q <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      done_q   <= 1'b0;
      pend_q   <= 1'b0;
      c2h_q    <= c2h_i;
      src_q    <= src_i;
      dst_q    <= dst_i;
      n_q      <= nwords_i;
      rd_idx_q <= '0;
      wr_idx_q <= '0;
    end else begin
      done_q <= 1'b0;
      pend_q <= rd_go;
      if (rd_go) rd_idx_q <= rd_idx_q + CNT_W'(1);
      if (pend_q) wr_idx_q <= wr_idx_q + CNT_W'(1);
      if (last_wr) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assert_wr_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (wr_idx_q < n_q));

  // once started, a write issues in every following busy cycle
  assert_stream_rate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$past(start_i)) |-> pend_q);
endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine
  import rce_pkg::*;
#(
  parameter int unsigned RING_DEPTH = 4,
  parameter int unsigned AW         = 32,
  parameter int unsigned LAW        = 10,
  localparam int unsigned IW        = $clog2(RING_DEPTH),
  localparam int unsigned FC_W      = $clog2(DESC_WRDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     ring_base_i,
  input  logic [AW-1:0]     status_addr_i,
  input  logic              irq_en_i,
  input  logic              pidx_we_i,
  input  logic [IW-1:0]     pidx_wdata_i,
  output logic              hm_req_o,
  output logic              hm_we_o,
  output logic [AW-1:0]     hm_addr_o,
  output logic [WORD_W-1:0] hm_wdata_o,
  input  logic [WORD_W-1:0] hm_rdata_i,
  output logic              lm_req_o,
  output logic              lm_we_o,
  output logic [LAW-1:0]    lm_addr_o,
  output logic [WORD_W-1:0] lm_wdata_o,
  input  logic [WORD_W-1:0] lm_rdata_i,
  output logic              irq_o
);
  eng_state_e       state_q;
  logic [FC_W-1:0]  fcnt_q;
  desc_t            desc_q;
  logic             irq_q;
  logic [IW-1:0]    pidx, cidx, cidx_nxt;
  logic             empty, adv;
  logic             fetch_last, cp_start, cp_busy, cp_done;
  logic [CNT_W-1:0] nwords;
  logic [AW-1:0]    fetch_addr;

  logic              cp_hm_req, cp_hm_we, cp_lm_req, cp_lm_we;
  logic [AW-1:0]     cp_hm_addr;
  logic [LAW-1:0]    cp_lm_addr;
  logic [WORD_W-1:0] cp_hm_wdata, cp_lm_wdata;

  rce_ring_idx #(.DEPTH(RING_DEPTH), .IW(IW)) u_idx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (pidx_we_i),
    .set_val_i  (pidx_wdata_i),
    .adv_i      (adv),
    .pidx_o     (pidx),
    .cidx_o     (cidx),
    .cidx_nxt_o (cidx_nxt),
    .empty_o    (empty)
  );

  assign nwords     = len_to_words(desc_q.ctrl);
  assign fetch_last = (state_q == ST_FETCH) && (fcnt_q == FC_W'(DESC_WRDS));
  assign cp_start   = fetch_last && (nwords != '0);
  assign adv        = (state_q == ST_STATUS);
  assign fetch_addr = ring_base_i + (AW'(cidx) << 5) + (AW'(fcnt_q) << 2);
  assign irq_o      = irq_q;

  rce_copier #(.AW(AW), .LAW(LAW)) u_copy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (cp_start),
    .c2h_i      (desc_q.ctrl[DIR_BIT]),
    .src_i      (AW'(desc_q.src)),
    .dst_i      (AW'(desc_q.dst)),
    .nwords_i   (nwords),
    .busy_o     (cp_busy),
    .done_o     (cp_done),
    .hm_req_o   (cp_hm_req),
    .hm_we_o    (cp_hm_we),
    .hm_addr_o  (cp_hm_addr),
    .hm_wdata_o (cp_hm_wdata),
    .hm_rdata_i (hm_rdata_i),
    .lm_req_o   (cp_lm_req),
    .lm_we_o    (cp_lm_we),
    .lm_addr_o  (cp_lm_addr),
    .lm_wdata_o (cp_lm_wdata),
    .lm_rdata_i (lm_rdata_i)
  );

  // host port shared by fetch, copy and status write-back
  always_comb begin
    hm_req_o   = cp_hm_req;
    hm_we_o    = cp_hm_we;
    hm_addr_o  = cp_hm_addr;
    hm_wdata_o = cp_hm_wdata;
    unique case (state_q)
      ST_FETCH: begin
        hm_req_o   = (fcnt_q < FC_W'(DESC_WRDS));
        hm_we_o    = 1'b0;
        hm_addr_o  = fetch_addr;
        hm_wdata_o = '0;
      end
      ST_STATUS: begin
        hm_req_o   = 1'b1;
        hm_we_o    = 1'b1;
        hm_addr_o  = status_addr_i;
        hm_wdata_o = WORD_W'(cidx_nxt);
      end
      default: ;
    endcase
  end

  assign lm_req_o   = cp_lm_req;
  assign lm_we_o    = cp_lm_we;
  assign lm_addr_o  = cp_lm_addr;
  assign lm_wdata_o = cp_lm_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fcnt_q  <= '0;
      desc_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          fcnt_q <= '0;
          if (!empty) state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          fcnt_q <= fcnt_q + FC_W'(1);
          // read data for word fcnt-1 arrives this cycle
          if (fcnt_q == FC_W'(1)) desc_q.src  <= hm_rdata_i;
          if (fcnt_q == FC_W'(3)) desc_q.ctrl <= hm_rdata_i;
          if (fcnt_q == FC_W'(5)) desc_q.dst  <= hm_rdata_i;
          if (fetch_last) state_q <= cp_start ? ST_COPY : ST_STATUS;
        end
        ST_COPY: begin
          if (cp_done) state_q <= ST_STATUS;
        end
        ST_STATUS: begin
          irq_q   <= irq_en_i && (cidx_nxt == pidx);
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && empty && !pidx_we_i) |=> (state_q == ST_IDLE));

  assert_irq_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_irq_after_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(state_q == ST_STATUS));

  assert_copy_owner_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_busy |-> (state_q == ST_COPY));
endmodule

// File: tb/ring_copy_engine_tb.sv
module ring_copy_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int AW         = 32;
  localparam int LAW        = 10;
  localparam logic [31:0] RING_BASE = 32'h6000;
  localparam logic [31:0] STAT_ADDR = 32'h7000;

  logic clk = 1'b0;
  logic rst_n;
  logic irq_en, pidx_we;
  logic [1:0] pidx_wdata;
  logic hm_req, hm_we, lm_req, lm_we, irq;
  logic [AW-1:0] hm_addr;
  logic [LAW-1:0] lm_addr;
  logic [31:0] hm_wdata, hm_rdata, lm_wdata, lm_rdata;

  logic [31:0] hmem [0:8191];
  logic [31:0] lmem [0:1023];

  logic tb_hwe, tb_lwe, cnt_clr, wd_hit;
  logic [12:0] tb_haddr;
  logic [9:0]  tb_laddr;
  logic [31:0] tb_hdata, tb_ldata;

  int checks, errors, sw_pidx;
  int n_hrd, n_hwr, n_lacc, n_lrd, n_lwr, n_irq, cyc, first_lwr, last_lwr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_copy_engine #(.RING_DEPTH(DEPTH), .AW(AW), .LAW(LAW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ring_base_i(RING_BASE), .status_addr_i(STAT_ADDR),
    .irq_en_i(irq_en), .pidx_we_i(pidx_we), .pidx_wdata_i(pidx_wdata),
    .hm_req_o(hm_req), .hm_we_o(hm_we), .hm_addr_o(hm_addr), .hm_wdata_o(hm_wdata),
    .hm_rdata_i(hm_rdata), .lm_req_o(lm_req), .lm_we_o(lm_we), .lm_addr_o(lm_addr),
    .lm_wdata_o(lm_wdata), .lm_rdata_i(lm_rdata), .irq_o(irq)
  );

  // memory models, one cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8192; i++) hmem[i] <= '0;
      for (int i = 0; i < 1024; i++) lmem[i] <= '0;
      hm_rdata <= '0;
      lm_rdata <= '0;
    end else begin
      if (hm_req && hm_we) hmem[hm_addr[14:2]] <= hm_wdata;
      else if (tb_hwe) hmem[tb_haddr] <= tb_hdata;
      if (hm_req && !hm_we) hm_rdata <= hmem[hm_addr[14:2]];
      if (lm_req && lm_we) lmem[lm_addr] <= lm_wdata;
      else if (tb_lwe) lmem[tb_laddr] <= tb_ldata;
      if (lm_req && !lm_we) lm_rdata <= lmem[lm_addr];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cnt_clr) begin
      n_hrd <= 0; n_hwr <= 0; n_lacc <= 0; n_lrd <= 0; n_lwr <= 0; n_irq <= 0;
      first_lwr <= 0; last_lwr <= 0;
    end else begin
      if (hm_req && !hm_we) n_hrd <= n_hrd + 1;
      if (hm_req && hm_we) n_hwr <= n_hwr + 1;
      if (lm_req) n_lacc <= n_lacc + 1;
      if (lm_req && !lm_we) n_lrd <= n_lrd + 1;
      if (lm_req && lm_we) begin
        n_lwr <= n_lwr + 1;
        if (n_lwr == 0) first_lwr <= cyc;
        last_lwr <= cyc;
      end
      if (irq) n_irq <= n_irq + 1;
    end
  end

  initial begin
    wd_hit = 1'b0;
    repeat (150000) @(posedge clk);
    wd_hit = 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int widx, input logic [31:0] d);
    @(negedge clk);
    tb_hwe = 1'b1; tb_haddr = 13'(widx); tb_hdata = d;
    @(posedge clk); #1 tb_hwe = 1'b0;
  endtask

  task automatic lw(input int widx, input logic [31:0] d);
    @(negedge clk);
    tb_lwe = 1'b1; tb_laddr = 10'(widx); tb_ldata = d;
    @(posedge clk); #1 tb_lwe = 1'b0;
  endtask

  task automatic put_desc(input int slot, input logic [31:0] src, input logic [31:0] dst,
                          input logic [31:0] ctrl);
    int b;
    b = int'(RING_BASE >> 2) + slot * 8;
    hw(b + 0, src);  hw(b + 1, 32'hDEAD_0001);
    hw(b + 2, ctrl); hw(b + 3, 32'hDEAD_0003);
    hw(b + 4, dst);  hw(b + 5, 32'hDEAD_0005);
    hw(b + 6, 32'hFFFF_FFFF); hw(b + 7, 32'h8000_1FFF);
  endtask

  task automatic prep();
    hw(int'(STAT_ADDR >> 2), 32'hFFFF_FFFF);
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
  endtask

  task automatic go(input int n);
    sw_pidx = (sw_pidx + n) % DEPTH;
    @(negedge clk); pidx_we = 1'b1; pidx_wdata = 2'(sw_pidx);
    @(negedge clk); pidx_we = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (hmem[STAT_ADDR >> 2] == 32'(sw_pidx)) break;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 irq in reset", 32'(irq), 0);
    check("R1 host req in reset", 32'(hm_req), 0);
    check("R1 local req in reset", 32'(lm_req), 0);
  endtask

  task automatic t_h2c();
    prep();
    for (int i = 0; i < 8; i++) hw(32'h100 + i, 32'h1100_0000 + i);
    put_desc(0, 32'h0400, 32'h0040, 32'h0000_0020);
    go(1);
    wait_done();
    for (int i = 0; i < 8; i++) check("R4 h2c local data", lmem[16 + i], 32'h1100_0000 + i);
    check("R8 status after h2c", hmem[STAT_ADDR >> 2], 1);
    check("R3 fetch reads", 32'(n_hrd), 8 + 8);
    check("R9 irq once", 32'(n_irq), 1);
    check("R10 consecutive writes", 32'(last_lwr - first_lwr), 7);
    check("R10 write count", 32'(n_lwr), 8);
  endtask

  task automatic t_c2h();
    prep();
    for (int i = 0; i < 7; i++) lw(100 + i, 32'hC0DE_0000 + i);
    hw(32'h806, 32'h77);
    put_desc(1, 32'd400, 32'h2000, 32'h8000_001A);
    go(1);
    wait_done();
    for (int i = 0; i < 6; i++) check("R4 c2h host data", hmem[32'h800 + i], 32'hC0DE_0000 + i);
    check("R5 leftover bytes dropped", hmem[32'h806], 32'h77);
    check("R8 status after c2h", hmem[STAT_ADDR >> 2], 2);
  endtask

  task automatic t_zero();
    prep();
    put_desc(2, 32'h0400, 32'h0000, 32'h0000_0003);
    go(1);
    wait_done();
    check("R6 no local access", 32'(n_lacc), 0);
    check("R6 only fetch reads", 32'(n_hrd), 8);
    check("R6 only status write", 32'(n_hwr), 1);
    check("R8 status after zero", hmem[STAT_ADDR >> 2], 3);
  endtask

  task automatic t_batch();
    prep();
    for (int i = 0; i < 4; i++) hw(32'h200 + i, 32'hA0 + i);
    for (int i = 0; i < 4; i++) hw(32'h240 + i, 32'hB0 + i);
    put_desc(3, 32'h0800, 32'd800, 32'h10);
    put_desc(0, 32'h0900, 32'd808, 32'h10);
    put_desc(1, 32'd800, 32'h3000, 32'h8000_0018);
    go(3);
    wait_done();
    check("R7 order word0", hmem[32'hC00], 32'hA0);
    check("R7 order word1", hmem[32'hC01], 32'hA1);
    for (int i = 0; i < 4; i++) check("R7 later overwrites", hmem[32'hC02 + i], 32'hB0 + i);
    check("R7 wrapped status", hmem[STAT_ADDR >> 2], 2);
    check("R9 one irq per batch", 32'(n_irq), 1);
    check("R8 status writes per desc", 32'(n_hwr), 3 + 6);
  endtask

  task automatic t_noirq();
    irq_en = 1'b0;
    prep();
    put_desc(2, 32'h0400, 32'h0000, 32'h8);
    go(1);
    wait_done();
    check("R9 no irq when disabled", 32'(n_irq), 0);
    check("R8 status polled", hmem[STAT_ADDR >> 2], 3);
    irq_en = 1'b1;
  endtask

  task automatic t_clamp();
    prep();
    lw(0, 32'h55); lw(1023, 32'h1234);
    hw(32'h1400, 32'hA5A5_A5A5);
    put_desc(3, 32'h0000, 32'h4000, 32'h8000_1004);
    go(1);
    wait_done();
    check("R5 clamp first", hmem[32'h1000], 32'h55);
    check("R5 clamp last", hmem[32'h13FF], 32'h1234);
    check("R5 clamp no overrun", hmem[32'h1400], 32'hA5A5_A5A5);
    check("R5 clamp read count", 32'(n_lrd), 1024);
    check("R7 wrap to zero", hmem[STAT_ADDR >> 2], 0);
  endtask

  task automatic t_idle_write();
    prep();
    go(0);
    repeat (40) @(negedge clk);
    check("R2 equal pidx no host traffic", 32'(n_hrd + n_hwr), 0);
    check("R2 equal pidx no local traffic", 32'(n_lacc), 0);
  endtask

  task automatic run_all();
    t_h2c();
    t_c2h();
    t_zero();
    t_batch();
    t_noirq();
    t_clamp();
    t_idle_write();
  endtask

  initial begin
    checks = 0; errors = 0; sw_pidx = 0; cyc = 0;
    rst_n = 1'b0; irq_en = 1'b1; pidx_we = 1'b0; pidx_wdata = '0;
    tb_hwe = 1'b0; tb_lwe = 1'b0; tb_haddr = '0; tb_laddr = '0;
    tb_hdata = '0; tb_ldata = '0; cnt_clr = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    check("R1 host idle after reset", 32'(hm_req), 0);
    fork
      run_all();
      wait (wd_hit);
    join_any
    if (wd_hit) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule